// File: doc/BRIEF.md
# Receive Packet-Length Queue

This block sits beside the receive data path of a packet link and keeps a record of how many bytes each completed packet carried. Each data byte strobe advances a running byte count; an end-of-packet strobe closes the packet and writes the finished count into a small first-in, first-out queue. The host takes one length out of the queue per read strobe. The value appears on a registered read-data port and stays there until the next read.

A status output tells the host that at least one unread length is waiting. A mode input decides what a read of an empty queue returns. In one setting it returns zero. In the other it returns the most recent packet length taken into the queue. Either way, software can read without first polling the status. A packet-disable input marks a mode in which the stream is not split into packets, so no lengths are recorded. A receive-FIFO clear input wipes the queue, the remembered length, the byte count and a sticky overflow flag. The overflow flag records that a length was lost because the queue was full.

Top module: `pkt_len_queue`

## Requirements
- R1: After reset, `len_avail`, `len_ovf` and `len_rd_data` are all 0.
- R2: `len_avail` is 1 in every cycle in which at least one unread length is queued, and 0 otherwise. A length accepted at a clock edge is visible from that edge on.
- R3: A recorded length counts every cycle with `rx_byte_vld`=1 since the previous end-of-packet. A byte strobed in the same cycle as `rx_eop` belongs to the packet being closed. An `rx_eop` with no preceding bytes records a length of 0.
- R4: A read (`len_rd_stb`=1 for one cycle) of a non-empty queue returns the oldest queued length on `len_rd_data` from the next clock edge and removes that length from the queue.
- R5: A read of an empty queue with `ctl_valid_only`=1 returns 0.
- R6: A read of an empty queue with `ctl_valid_only`=0 returns the length most recently accepted into the queue, sampled before any push in the same cycle. After reset or a clear, that length is 0.
- R7: While `ctl_pkt_disable`=1, `rx_eop` records nothing and the byte count is held at 0.
- R8: An end-of-packet that arrives while the queue holds `DEPTH` entries and no read is popping is dropped. It sets `len_ovf`, which stays 1 until a clear.
- R9: A push and a pop in the same cycle leave the occupancy unchanged, and the read returns the oldest entry. This is also true when the queue is full.
- R10: `rx_fifo_clr`=1 empties the queue and zeroes the remembered length, the byte count and `len_ovf` at that edge. Reads and end-of-packet strobes in that cycle are ignored.
- R11: `len_rd_data` changes only at an edge where a read is taken. It holds its value otherwise, including across a clear.
- R12: Lengths leave the queue in the order in which their packets ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_fifo_clr | input | 1 | Receive FIFO clear, synchronous |
| ctl_valid_only | input | 1 | 1: an empty read returns 0; 0: an empty read returns the last length |
| ctl_pkt_disable | input | 1 | 1: no packet framing, no lengths recorded |
| rx_byte_vld | input | 1 | One received data byte this cycle |
| rx_eop | input | 1 | End-of-packet marker this cycle |
| len_rd_stb | input | 1 | Host read strobe, pops one length |
| len_rd_data | output | LEN_W | Registered read result |
| len_avail | output | 1 | At least one unread length is queued |
| len_ovf | output | 1 | Sticky: a length was dropped on a full queue |

## Verification
The bench builds the block with `DEPTH`=4 and the default `LEN_W`=32. With the small depth, filling the queue, overflowing it, popping while full and wrapping the pointers all happen within a few dozen cycles, so both the random phase and the directed cases reach them many times. Random end-of-packet strobes run against random reads, both empty-read modes, short disable windows and rare clears. Directed cases cover zero-length packets, a byte that arrives together with its end marker, and a push that coincides with a pop.

// File: rtl/pkt_len_pkg.sv
package pkt_len_pkg;

    // Lengths up to two gigabytes must fit in one entry.
    localparam int unsigned LEN_W_MIN = 31;

    // Source of the value loaded into the read-data register.
    typedef enum logic [1:0] {
        RD_SRC_NONE = 2'd0,
        RD_SRC_HEAD = 2'd1,
        RD_SRC_ZERO = 2'd2,
        RD_SRC_LAST = 2'd3
    } rd_src_e;

endpackage

// File: rtl/len_counter.sv
module len_counter #(
    parameter int unsigned LEN_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             pkt_disable,
    input  logic             byte_vld,
    input  logic             eop,
    output logic             push,
    output logic [LEN_W-1:0] push_len
);

    typedef struct packed {
        logic [LEN_W-1:0] cnt;
    } cnt_st_t;

    localparam logic [LEN_W-1:0] ONE = {{(LEN_W-1){1'b0}}, 1'b1};

    cnt_st_t st_d, st_q;
    logic [LEN_W-1:0] len_now;

    always_comb begin
        st_d = st_q;
        // A byte in the end-marker cycle still belongs to the closing packet;
        // the count saturates instead of wrapping.
        if (byte_vld && (st_q.cnt != {LEN_W{1'b1}})) begin
            len_now = st_q.cnt + ONE;
        end else begin
            len_now = st_q.cnt;
        end

        push     = eop && !pkt_disable && !clear;
        push_len = len_now;

        if (clear || pkt_disable || eop) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = len_now;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/len_fifo.sv
module len_fifo #(
    parameter int unsigned LEN_W = 32,
    parameter int unsigned DEPTH = 16
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           clear,
    input  logic                           push,
    input  logic [LEN_W-1:0]               push_data,
    input  logic                           pop_req,
    output logic [LEN_W-1:0]               head,
    output logic                           empty,
    output logic                           push_acc,
    output logic                           pop_acc,
    output logic [$clog2(DEPTH+1)-1:0]     occ,
    output logic                           ovf
);

    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
    localparam logic [PTR_W-1:0] PTR_ONE  = PTR_W'(1);

    typedef struct packed {
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] rd;
        logic [CNT_W-1:0] cnt;
        logic             ovf;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic [LEN_W-1:0] mem [DEPTH];
    logic full;

    always_comb begin
        st_d     = st_q;
        empty    = (st_q.cnt == '0);
        full     = (st_q.cnt == CNT_FULL);
        pop_acc  = pop_req && !empty && !clear;
        // A pop in the same cycle frees the slot a full queue needs.
        push_acc = push && !clear && (!full || pop_acc);

        if (clear) begin
            st_d = '0;
        end else begin
            if (push_acc) begin
                st_d.wr = (st_q.wr == PTR_LAST) ? '0 : st_q.wr + PTR_ONE;
            end
            if (pop_acc) begin
                st_d.rd = (st_q.rd == PTR_LAST) ? '0 : st_q.rd + PTR_ONE;
            end
            unique case ({push_acc, pop_acc})
                2'b10:   st_d.cnt = st_q.cnt + CNT_ONE;
                2'b01:   st_d.cnt = st_q.cnt - CNT_ONE;
                default: st_d.cnt = st_q.cnt;
            endcase
            if (push && !push_acc) begin
                st_d.ovf = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Storage carries no reset; occupancy alone says what is valid.
    always_ff @(posedge clk) begin
        if (push_acc) begin
            mem[st_q.wr] <= push_data;
        end
    end

    assign head = mem[st_q.rd];
    assign occ  = st_q.cnt;
    assign ovf  = st_q.ovf;

endmodule

// File: rtl/len_read_port.sv
module len_read_port
    import pkt_len_pkg::*;
#(
    parameter int unsigned LEN_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             rd_stb,
    input  logic             empty,
    input  logic [LEN_W-1:0] head,
    input  logic             push_acc,
    input  logic [LEN_W-1:0] push_len,
    input  logic             valid_only,
    output logic [LEN_W-1:0] rd_data
);

    typedef struct packed {
        logic [LEN_W-1:0] rd_data;
        logic [LEN_W-1:0] last;
    } rp_st_t;

    rp_st_t  st_d, st_q;
    rd_src_e src;

    always_comb begin
        st_d = st_q;
        src  = RD_SRC_NONE;
        if (rd_stb && !clear) begin
            if (!empty) begin
                src = RD_SRC_HEAD;
            end else if (valid_only) begin
                src = RD_SRC_ZERO;
            end else begin
                src = RD_SRC_LAST;
            end
        end

        unique case (src)
            RD_SRC_HEAD: st_d.rd_data = head;
            RD_SRC_ZERO: st_d.rd_data = '0;
            RD_SRC_LAST: st_d.rd_data = st_q.last;
            default:     st_d.rd_data = st_q.rd_data;
        endcase

        if (clear) begin
            st_d.last = '0;
        end else if (push_acc) begin
            st_d.last = push_len;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data = st_q.rd_data;

endmodule

// File: rtl/pkt_len_queue.sv
module pkt_len_queue #(
    parameter int unsigned LEN_W = 32,
    parameter int unsigned DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_fifo_clr,
    input  logic             ctl_valid_only,
    input  logic             ctl_pkt_disable,
    input  logic             rx_byte_vld,
    input  logic             rx_eop,
    input  logic             len_rd_stb,
    output logic [LEN_W-1:0] len_rd_data,
    output logic             len_avail,
    output logic             len_ovf
);

    localparam int unsigned OCC_W = $clog2(DEPTH + 1);

    logic             push_w;
    logic [LEN_W-1:0] push_len_w;
    logic [LEN_W-1:0] head_w;
    logic             empty_w;
    logic             push_acc_w;
    logic             pop_acc_w;
    logic [OCC_W-1:0] occ_w;

    len_counter #(.LEN_W(LEN_W)) cnt_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (rx_fifo_clr),
        .pkt_disable (ctl_pkt_disable),
        .byte_vld    (rx_byte_vld),
        .eop         (rx_eop),
        .push        (push_w),
        .push_len    (push_len_w)
    );

    len_fifo #(.LEN_W(LEN_W), .DEPTH(DEPTH)) fifo_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (rx_fifo_clr),
        .push      (push_w),
        .push_data (push_len_w),
        .pop_req   (len_rd_stb),
        .head      (head_w),
        .empty     (empty_w),
        .push_acc  (push_acc_w),
        .pop_acc   (pop_acc_w),
        .occ       (occ_w),
        .ovf       (len_ovf)
    );

    len_read_port #(.LEN_W(LEN_W)) rdp_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (rx_fifo_clr),
        .rd_stb     (len_rd_stb),
        .empty      (empty_w),
        .head       (head_w),
        .push_acc   (push_acc_w),
        .push_len   (push_len_w),
        .valid_only (ctl_valid_only),
        .rd_data    (len_rd_data)
    );

    assign len_avail = !empty_w;

endmodule

// File: rtl/pkt_len_queue_chk.sv
module pkt_len_queue_chk #(
    parameter int unsigned LEN_W = 32,
    parameter int unsigned CNT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clr,
    input logic             vo,
    input logic             dis,
    input logic             rd,
    input logic [LEN_W-1:0] rd_data,
    input logic             avail,
    input logic             ovf,
    input logic [CNT_W-1:0] occ,
    input logic             push_acc,
    input logic             pop_acc
);

    assert_avail_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (push_acc && !pop_acc) |=> avail);

    assert_avail_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == CNT_W'(1) && pop_acc && !push_acc) |=> !avail);

    assert_empty_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !avail && vo && !clr) |=> (rd_data == '0));

    assert_disable_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dis && !avail) |=> !avail);

    assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !clr) |=> ovf);

    assert_pushpop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (push_acc && pop_acc) |=> $stable(occ));

    assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!avail && !ovf));

    assert_rd_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd || clr) |=> $stable(rd_data));

endmodule

bind pkt_len_queue pkt_len_queue_chk #(.LEN_W(LEN_W), .CNT_W(OCC_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (rx_fifo_clr),
    .vo       (ctl_valid_only),
    .dis      (ctl_pkt_disable),
    .rd       (len_rd_stb),
    .rd_data  (len_rd_data),
    .avail    (len_avail),
    .ovf      (len_ovf),
    .occ      (occ_w),
    .push_acc (push_acc_w),
    .pop_acc  (pop_acc_w)
);

// File: tb/pkt_len_queue_tb_top.sv
module pkt_len_queue_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int LEN_W      = 32;
    localparam int DEPTH      = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             rx_fifo_clr = 1'b0;
    logic             ctl_valid_only = 1'b0;
    logic             ctl_pkt_disable = 1'b0;
    logic             rx_byte_vld = 1'b0;
    logic             rx_eop = 1'b0;
    logic             len_rd_stb = 1'b0;
    logic [LEN_W-1:0] len_rd_data;
    logic             len_avail;
    logic             len_ovf;

    int n_chk  = 0;
    int n_fail = 0;

    // Reference state
    logic [LEN_W-1:0] mq[$];
    logic [LEN_W-1:0] m_cnt = '0;
    logic [LEN_W-1:0] m_last = '0;
    logic [LEN_W-1:0] m_rd = '0;
    logic             m_ovf = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pkt_len_queue #(.LEN_W(LEN_W), .DEPTH(DEPTH)) dut_i (
        .clk             (clk),
        .rst_n           (rst_n),
        .rx_fifo_clr     (rx_fifo_clr),
        .ctl_valid_only  (ctl_valid_only),
        .ctl_pkt_disable (ctl_pkt_disable),
        .rx_byte_vld     (rx_byte_vld),
        .rx_eop          (rx_eop),
        .len_rd_stb      (len_rd_stb),
        .len_rd_data     (len_rd_data),
        .len_avail       (len_avail),
        .len_ovf         (len_ovf)
    );

    task automatic check(input string req, input string ph,
                         input logic [LEN_W-1:0] act, input logic [LEN_W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s (%s) at %0t: got %0d expected %0d", req, ph, $time, act, exp);
        end
    endtask

    // Expected read result for a read taken now against the reference state.
    function automatic logic [LEN_W-1:0] exp_read(input logic vo);
        if (mq.size() > 0) return mq[0];
        return vo ? '0 : m_last;
    endfunction

    function automatic string read_tag(input logic rd, input logic vo, input int sz);
        if (!rd) return "R11";
        if (sz > 0) return "R4";
        return vo ? "R5" : "R6";
    endfunction

    // One clock: drive at negedge, update the model at posedge, compare after it.
    task automatic step(input logic ck, input logic bv, input logic eop,
                        input logic dis, input logic rd, input logic vo,
                        input string ph);
        string rtag;
        logic [LEN_W-1:0] len;
        logic popok;
        @(negedge clk);
        rx_fifo_clr     = ck;
        rx_byte_vld     = bv;
        rx_eop          = eop;
        ctl_pkt_disable = dis;
        len_rd_stb      = rd;
        ctl_valid_only  = vo;
        @(posedge clk);
        rtag = read_tag(rd && !ck, vo, mq.size());
        if (ck) begin
            mq.delete();
            m_cnt  = '0;
            m_last = '0;
            m_ovf  = 1'b0;
            rtag   = "R10";
        end else begin
            popok = rd && (mq.size() > 0);
            if (rd) m_rd = exp_read(vo);
            len = (bv && m_cnt != '1) ? m_cnt + 1 : m_cnt;
            if (popok) void'(mq.pop_front());
            if (dis) begin
                m_cnt = '0;
            end else if (eop) begin
                m_cnt = '0;
                if (mq.size() < DEPTH) begin
                    mq.push_back(len);
                    m_last = len;
                end else begin
                    m_ovf = 1'b1;
                end
            end else begin
                m_cnt = len;
            end
        end
        #1;
        check(rtag, ph, len_rd_data, m_rd);
        check("R2", ph, LEN_W'(len_avail), LEN_W'(mq.size() > 0));
        check("R8", ph, LEN_W'(len_ovf), LEN_W'(m_ovf));
    endtask

    task automatic idle(input int n, input string ph);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, ph);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin : stim
        void'($urandom(32'h1f3c_5a07));
        repeat (3) @(posedge clk);
        #1;
        // R1: reset values
        check("R1", "reset", LEN_W'(len_avail), '0);
        check("R1", "reset", LEN_W'(len_ovf), '0);
        check("R1", "reset", len_rd_data, '0);
        @(negedge clk);
        rst_n = 1'b1;
        idle(2, "R1");

        // R3: four bytes, a gap, then a byte together with its end marker -> 5
        for (int i = 0; i < 4; i++) step(0, 1, 0, 0, 0, 0, "R3");
        step(0, 0, 0, 0, 0, 0, "R3");
        step(0, 1, 1, 0, 0, 0, "R3");
        // R3: end marker with no bytes -> 0
        step(0, 0, 1, 0, 0, 0, "R3");
        step(0, 0, 0, 0, 1, 0, "R3_R4");
        check("R3", "len5", len_rd_data, 32'd5);
        step(0, 0, 0, 0, 1, 0, "R3_R4");
        check("R3", "len0", len_rd_data, 32'd0);

        // R6 / R5: empty reads in both modes
        for (int i = 0; i < 3; i++) step(0, 1, 0, 0, 0, 0, "R6");
        step(0, 0, 1, 0, 0, 0, "R6");
        step(0, 0, 0, 0, 1, 0, "R6");
        step(0, 0, 0, 0, 1, 0, "R6");
        check("R6", "empty_last", len_rd_data, 32'd3);
        step(0, 0, 0, 0, 1, 1, "R5");
        check("R5", "empty_zero", len_rd_data, 32'd0);

        // R8 / R12: overfill with lengths 1..DEPTH+2, read back in order
        for (int p = 1; p <= DEPTH + 2; p++) begin
            for (int b = 1; b < p; b++) step(0, 1, 0, 0, 0, 0, "R8");
            step(0, 1, 1, 0, 0, 0, "R8");
        end
        check("R8", "ovf_set", LEN_W'(len_ovf), 32'd1);
        for (int p = 1; p <= DEPTH; p++) begin
            step(0, 0, 0, 0, 1, 1, "R12");
            check("R12", "order", len_rd_data, LEN_W'(p));
        end
        check("R8", "ovf_sticky", LEN_W'(len_ovf), 32'd1);

        // R9: push and pop together, from a full queue
        for (int p = 0; p < DEPTH; p++) step(0, 1, 1, 0, 0, 0, "R9");
        step(0, 1, 0, 0, 0, 0, "R9");
        step(0, 1, 1, 0, 1, 0, "R9");
        check("R9", "oldest", len_rd_data, 32'd1);
        for (int p = 0; p < DEPTH; p++) step(0, 0, 0, 0, 1, 0, "R9_drain");
        check("R9", "newest_kept", len_rd_data, 32'd2);

        // R10: clear with a partly filled queue and a byte count in progress
        step(0, 1, 1, 0, 0, 0, "R10");
        step(0, 1, 0, 0, 0, 0, "R10");
        step(1, 1, 1, 0, 1, 0, "R10");
        step(0, 0, 0, 0, 1, 0, "R10");
        check("R10", "last_zero", len_rd_data, 32'd0);
        step(0, 1, 1, 0, 0, 0, "R10");
        step(0, 0, 0, 0, 1, 0, "R10");
        check("R10", "count_zero", len_rd_data, 32'd1);

        // R7: disabled framing records nothing and holds the count at zero
        for (int i = 0; i < 3; i++) step(0, 1, 0, 1, 0, 0, "R7");
        step(0, 1, 1, 1, 0, 0, "R7");
        check("R7", "no_push", LEN_W'(len_avail), 32'd0);
        step(0, 1, 1, 0, 0, 0, "R7");
        step(0, 0, 0, 0, 1, 0, "R7");
        check("R7", "count_held", len_rd_data, 32'd1);

        // Random traffic
        for (int i = 0; i < 4000; i++) begin
            logic ck, bv, eop, dis, rd, vo;
            ck  = ($urandom_range(0, 199) == 0);
            bv  = ($urandom_range(0, 9) < 6);
            eop = ($urandom_range(0, 5) == 0);
            dis = ($urandom_range(0, 29) == 0);
            rd  = ($urandom_range(0, 3) == 0);
            vo  = ($urandom_range(0, 1) == 1);
            step(ck, bv, eop, dis, rd, vo, "random");
        end

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule